// File: doc/BRIEF.md
# ALU With Two-Level Operation Decoder

This block is a purely combinational 32-bit arithmetic logic unit that carries its own control decoder. A processor's main control supplies a 2-bit operation class, and, for register-to-register instructions, the low six bits of the instruction word (the function field). The decoder turns the pair into a 3-bit ALU control code. The ALU then performs a bitwise AND, bitwise OR, addition, subtraction or signed set-on-less-than on the two operands.

The ALU reports the result, a zero flag, a signed overflow flag and the carry out of the most significant bit. There is no carry-in port. Subtraction and set-on-less-than share one adder: the adder inverts the second operand and forces its internal carry-in to 1. A branch unit uses the zero flag after a class-01 subtraction to test two registers for equality. An address generator uses class 00 to add a base and an offset.

Top module: `alu_core`

## Requirements
- R1: When op_class is 2'b00 (memory access), the ALU adds a and b, whatever the value of funct.
- R2: When op_class is 2'b01 (branch compare), the ALU computes a minus b, whatever the value of funct.
- R3: When op_class is 2'b10 (register arithmetic), funct selects the operation: 6'h20 add, 6'h22 subtract, 6'h24 AND, 6'h25 OR, 6'h2A set-on-less-than. The internal control codes are 3'b000 AND, 3'b001 OR, 3'b010 add, 3'b110 subtract and 3'b111 set-on-less-than.
- R4: When op_class is 2'b10 and funct holds any other value, the ALU adds. When op_class is 2'b11 (jump), the ALU also adds.
- R5: AND gives a & b and OR gives a | b, bit by bit.
- R6: Add gives (a + b) mod 2^32. For add, AND and OR, carry_out is the carry out of bit 31 of a + b.
- R7: Subtract gives (a - b) mod 2^32, computed as a + ~b + 1. For subtract and set-on-less-than, carry_out is the carry out of bit 31 of that sum, so it is 1 exactly when a >= b as unsigned numbers.
- R8: For add and subtract, overflow is 1 exactly when the two's-complement result does not fit in 32 bits. For AND, OR and set-on-less-than, overflow is 0.
- R9: Set-on-less-than gives 32'd1 when a < b as signed numbers and 32'd0 otherwise. It takes this from the sign of a - b XOR that subtraction's overflow, so bits 31:1 are always 0.
- R10: zero is 1 exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main control |
| funct | input | 6 | Function field, low six instruction bits |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | ALU result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry out of the adder's top bit |

## Verification
The bound checker evaluates properties that hold for every operand value whenever the inputs change. It checks that classes 00 and 01 force the add and subtract codes and that the decoder only produces legal codes. It also checks that AND matches a & b, that set-on-less-than never sets bits 31:1, that overflow stays low outside add and subtract, and that zero agrees with the result. The bench scenarios are needed for the arithmetic values themselves. Those cover exact sums and differences, carry out, and signed overflow at the boundaries (most negative and most positive values, equal operands). They also cover the set-on-less-than cases where the raw sign bit of the difference is wrong and overflow corrects it, and the default mapping of unknown function codes and of the jump class.

// File: rtl/alu_pkg.sv
// Package: shared encodings for the ALU and its decoder.
// Assumes: control codes and class codes are fixed by the surrounding control.
package alu_pkg;

    // ALU control code driven by the decoder into the datapath
    typedef enum logic [2:0] {
        CTRL_AND = 3'b000,
        CTRL_OR  = 3'b001,
        CTRL_ADD = 3'b010,
        CTRL_SUB = 3'b110,
        CTRL_SLT = 3'b111
    } alu_ctrl_e;

    // Operation class from the main control
    typedef enum logic [1:0] {
        CLS_MEM    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_REG    = 2'b10,
        CLS_JUMP   = 2'b11
    } op_class_e;

    localparam int FUNCT_W = 6;

    // Function-field codes recognised in the register class
    localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu_op_decoder.sv
// Module: alu_op_decoder
// Maps a 2-bit operation class plus the function field onto a 3-bit ALU
// control code. Assumes: purely combinational, unknown codes fall to add.
module alu_op_decoder
    import alu_pkg::*;
(
    input  logic [1:0]         op_class,
    input  logic [FUNCT_W-1:0] funct,
    output alu_ctrl_e          ctrl
);

    alu_ctrl_e reg_ctrl;

    // Decode the function field for register-class instructions
    always_comb begin
        unique case (funct)
            FN_ADD:  reg_ctrl = CTRL_ADD;
            FN_SUB:  reg_ctrl = CTRL_SUB;
            FN_AND:  reg_ctrl = CTRL_AND;
            FN_OR:   reg_ctrl = CTRL_OR;
            FN_SLT:  reg_ctrl = CTRL_SLT;
            default: reg_ctrl = CTRL_ADD;
        endcase
    end

    // Choose between forced class operations and the function decode
    always_comb begin
        unique case (op_class)
            CLS_MEM:    ctrl = CTRL_ADD;
            CLS_BRANCH: ctrl = CTRL_SUB;
            CLS_REG:    ctrl = reg_ctrl;
            default:    ctrl = CTRL_ADD;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
// Module: alu_addsub
// Ripple-carry adder/subtractor built from per-bit full-adder slices.
// In subtract mode the second operand is inverted and the hidden carry-in
// is 1. Assumes WIDTH >= 2. Provides sum, top carry and signed overflow.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] sum,
    output logic             carry_top,
    output logic             ovf
);

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] rhs_eff;

    // Invert the second operand for subtraction
    assign rhs_eff  = rhs ^ {WIDTH{sub_mode}};
    // Hidden carry-in is the subtract select
    assign carry[0] = sub_mode;

    // One full-adder slice per bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        assign sum[i]     = lhs[i] ^ rhs_eff[i] ^ carry[i];
        assign carry[i+1] = (lhs[i] & rhs_eff[i]) | (carry[i] & (lhs[i] ^ rhs_eff[i]));
    end

    assign carry_top = carry[WIDTH];
    // Signed overflow: carries into and out of the sign bit disagree
    assign ovf       = carry[WIDTH] ^ carry[WIDTH-1];

endmodule

// File: rtl/alu_result_mux.sv
// Module: alu_result_mux
// Forms the logic results and set-on-less-than, then selects the final
// result and gates the overflow flag. Assumes the adder is already in
// subtract mode whenever the code is subtract or set-on-less-than.
module alu_result_mux
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_ctrl_e        ctrl,
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic [WIDTH-1:0] sum,
    input  logic             sum_ovf,
    output logic [WIDTH-1:0] res,
    output logic             ovf_out
);

    logic less;

    // Signed less-than from difference sign corrected by overflow
    assign less = sum[WIDTH-1] ^ sum_ovf;

    // Select the result for the active operation
    always_comb begin
        unique case (ctrl)
            CTRL_AND: res = lhs & rhs;
            CTRL_OR:  res = lhs | rhs;
            CTRL_SLT: res = {{(WIDTH-1){1'b0}}, less};
            default:  res = sum;
        endcase
    end

    // Overflow is reported only by add and subtract
    always_comb begin
        ovf_out = 1'b0;
        if (ctrl == CTRL_ADD || ctrl == CTRL_SUB) ovf_out = sum_ovf;
    end

endmodule

// File: rtl/alu_core.sv
// Module: alu_core (top)
// Combinational 32-bit ALU with its own operation decoder. Assumes no
// clock or reset is needed: outputs follow inputs within one evaluation.
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]         op_class,
    input  logic [FUNCT_W-1:0] funct,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [WIDTH-1:0]   result,
    output logic               zero,
    output logic               overflow,
    output logic               carry_out
);

    alu_ctrl_e        alu_ctrl;
    logic             sub_mode;
    logic [WIDTH-1:0] sum;
    logic             sum_ovf;

    alu_op_decoder u_dec (
        .op_class (op_class),
        .funct    (funct),
        .ctrl     (alu_ctrl)
    );

    // Subtract path serves both subtract and set-on-less-than
    assign sub_mode = (alu_ctrl == CTRL_SUB) || (alu_ctrl == CTRL_SLT);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .lhs       (a),
        .rhs       (b),
        .sub_mode  (sub_mode),
        .sum       (sum),
        .carry_top (carry_out),
        .ovf       (sum_ovf)
    );

    alu_result_mux #(.WIDTH(WIDTH)) u_mux (
        .ctrl    (alu_ctrl),
        .lhs     (a),
        .rhs     (b),
        .sum     (sum),
        .sum_ovf (sum_ovf),
        .res     (result),
        .ovf_out (overflow)
    );

    // Zero flag over the full result
    assign zero = ~|result;

endmodule

// File: rtl/alu_core_checker.sv
// Module: alu_core_checker
// Combinational property checks bound into alu_core. Assumes inputs are
// settled when each always_comb block evaluates.
module alu_core_checker
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [1:0]       op_class,
    input alu_ctrl_e        alu_ctrl,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             overflow
);

    // Class and decoder checks
    always_comb begin
        p_mem_add_r1: assert (op_class != CLS_MEM || alu_ctrl == CTRL_ADD)
            else $error("R1 memory class not add");
        p_branch_sub_r2: assert (op_class != CLS_BRANCH || alu_ctrl == CTRL_SUB)
            else $error("R2 branch class not subtract");
        p_legal_code_r3: assert (alu_ctrl inside {CTRL_AND, CTRL_OR, CTRL_ADD, CTRL_SUB, CTRL_SLT})
            else $error("R3 illegal control code");
    end

    // Datapath output checks
    always_comb begin
        p_and_value_r5: assert (alu_ctrl != CTRL_AND || result == (a & b))
            else $error("R5 AND result wrong");
        p_no_overflow_r8: assert (alu_ctrl == CTRL_ADD || alu_ctrl == CTRL_SUB || !overflow)
            else $error("R8 overflow outside add/sub");
        p_slt_range_r9: assert (alu_ctrl != CTRL_SLT || result[WIDTH-1:1] == '0)
            else $error("R9 upper result bits set");
        p_zero_flag_r10: assert (zero == (result == '0))
            else $error("R10 zero flag mismatch");
    end

endmodule

bind alu_core alu_core_checker #(.WIDTH(WIDTH)) u_chk (
    .op_class (op_class),
    .alu_ctrl (alu_ctrl),
    .a        (a),
    .b        (b),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
);

// File: tb/alu_core_tb.sv
module alu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_class;
    logic [5:0]  funct;
    logic [31:0] a, b;
    logic [31:0] result;
    logic        zero, overflow, carry_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    alu_core u_dut (
        .op_class (op_class), .funct (funct), .a (a), .b (b),
        .result (result), .zero (zero), .overflow (overflow), .carry_out (carry_out)
    );

    // Expected operation: 0 and, 1 or, 2 add, 3 sub, 4 slt
    function automatic int exp_op(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return 2;
        if (c == 2'b01) return 3;
        if (c == 2'b11) return 2;
        case (f)
            6'h20: return 2;
            6'h22: return 3;
            6'h24: return 0;
            6'h25: return 1;
            6'h2A: return 4;
            default: return 2;
        endcase
    endfunction

    task automatic apply(input logic [1:0] c, input logic [5:0] f,
                         input logic [31:0] x, input logic [31:0] y, input string tag);
        int          op;
        logic [32:0] s_add, s_sub;
        logic [31:0] e_res;
        logic        e_ovf, e_cy;
        @(negedge clk);
        op_class = c; funct = f; a = x; b = y;
        #1;
        op    = exp_op(c, f);
        s_add = {1'b0, x} + {1'b0, y};
        s_sub = {1'b0, x} + {1'b0, ~y} + 33'd1;
        e_ovf = 1'b0;
        e_cy  = (op == 3 || op == 4) ? s_sub[32] : s_add[32];
        case (op)
            0: e_res = x & y;
            1: e_res = x | y;
            2: begin e_res = s_add[31:0]; e_ovf = (x[31] == y[31]) && (s_add[31] != x[31]); end
            3: begin e_res = s_sub[31:0]; e_ovf = (x[31] != y[31]) && (s_sub[31] != x[31]); end
            default: e_res = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
        endcase
        n_vec++;
        if (result !== e_res || zero !== (e_res == 32'd0) || overflow !== e_ovf || carry_out !== e_cy) begin
            n_bad++;
            $display("FAIL %s cls=%b fn=%h a=%h b=%h: got res=%h z=%b v=%b c=%b exp res=%h z=%b v=%b c=%b",
                     tag, c, f, x, y, result, zero, overflow, carry_out,
                     e_res, (e_res == 32'd0), e_ovf, e_cy);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        op_class = 2'b00; funct = 6'h00; a = '0; b = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // Reset-state style check: all-zero inputs give add of zeros (R10 zero high)
        apply(2'b00, 6'h00, 32'd0, 32'd0, "R10 idle zero");
        // R1 memory class forces add regardless of funct
        apply(2'b00, 6'h24, 32'd1000, 32'd32, "R1 address add");
        apply(2'b00, 6'h2A, 32'hFFFF_FFFF, 32'd1, "R1 add wrap R6 carry");
        // R2 branch class forces subtract; equal operands give zero
        apply(2'b01, 6'h25, 32'h1234_5678, 32'h1234_5678, "R2 equal compare R10");
        apply(2'b01, 6'h20, 32'd5, 32'd7, "R2 unequal R7 borrow");
        // R3 function decode
        apply(2'b10, 6'h20, 32'h7FFF_FFFF, 32'd1, "R3 add R8 ovf");
        apply(2'b10, 6'h22, 32'h8000_0000, 32'd1, "R3 sub R8 ovf");
        apply(2'b10, 6'h24, 32'hF0F0_00FF, 32'h0FF0_F00F, "R3 and R5");
        apply(2'b10, 6'h25, 32'hF0F0_0000, 32'h0000_0F0F, "R3 or R5");
        apply(2'b10, 6'h24, 32'hAAAA_AAAA, 32'h5555_5555, "R5 and zero R10");
        // R9 set-on-less-than including overflow-corrected cases
        apply(2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, "R9 slt min<max");
        apply(2'b10, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000, "R9 slt max>min");
        apply(2'b10, 6'h2A, 32'hFFFF_FFFF, 32'd0, "R9 slt -1<0");
        apply(2'b10, 6'h2A, 32'd3, 32'd3, "R9 slt equal");
        // R4 default mappings
        apply(2'b10, 6'h00, 32'd10, 32'd20, "R4 unknown funct add");
        apply(2'b10, 6'h3F, 32'h8000_0000, 32'h8000_0000, "R4 unknown funct R8 ovf");
        apply(2'b11, 6'h22, 32'd9, 32'd4, "R4 jump class add");
        // R7 carry when a >= b unsigned, R6 carry on no wrap
        apply(2'b10, 6'h22, 32'hFFFF_FFFF, 32'd1, "R7 sub carry");
        apply(2'b10, 6'h20, 32'd1, 32'd1, "R6 add no carry");
        // Constrained random: bias operands toward extremes
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2000; i++) begin
            logic [1:0]  rc;
            logic [5:0]  rf;
            logic [31:0] ra, rb;
            int          pick;
            rc   = 2'($urandom_range(0, 3));
            pick = $urandom_range(0, 6);
            case (pick)
                0: rf = 6'h20; 1: rf = 6'h22; 2: rf = 6'h24;
                3: rf = 6'h25; 4: rf = 6'h2A;
                default: rf = 6'($urandom);
            endcase
            ra = $urandom;
            rb = ($urandom_range(0, 7) == 0) ? ra : $urandom;
            if ($urandom_range(0, 7) == 0) ra = {ra[31], 31'h0};
            apply(rc, rf, ra, rb, "R6 R7 R8 R9 random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule